// File: doc/BRIEF.md
# Lockstep Pipeline Valid Controller

This block governs a fixed-depth register pipeline whose entry and exit both use a valid/ready handshake. It keeps one valid flag per register stage and produces a single stage-enable signal that feeds the clock-enable of every data register. The whole pipeline therefore moves forward together, or holds together. The decision to move depends only on two things: whether the last stage holds an item, and whether the consumer is ready. Only the valid flags are reset. The data registers have no reset, because the valid flags already say which stages hold meaningful data.

A parameterised data chain is included and driven by the same enable, so the block can be exercised end to end. The depth parameter counts every register from the entry to the exit. A layout with an entry register, then combinational logic, then an exit register is therefore depth 2. The default depth is 3. A clock-enable input, active high, stops the pipeline and entry acceptance as a whole. The reset polarity is a parameter.

Top module: `lockstep_pipe`

## Requirements
- R1: While reset is at its active level (parameter `RST_LEVEL`, default 1), every valid flag is cleared. In the first cycle after reset, `dn_valid` is 0 and, with `clk_en` high, `up_ready` is 1.
- R2: `stage_en` and `up_ready` are always equal. Both are high exactly when `clk_en` is high and either `dn_valid` is 0 or `dn_ready` is 1.
- R3: While `clk_en` is 0, `stage_en` and `up_ready` are 0. No item is accepted even if `up_valid` is 1, and no stage advances, so `dn_valid` and `dn_data` hold.
- R4: An item accepted at a clock edge appears on `dn_valid`/`dn_data` after exactly `DEPTH` enabled clock edges, counting the accepting edge.
- R5: While `dn_valid` is 1 and `dn_ready` is 0, `dn_valid` and `dn_data` stay unchanged at the next edge.
- R6: Every upstream transfer (`up_valid` and `up_ready` both 1 at an edge) produces exactly one downstream transfer (`dn_valid` and `dn_ready` both 1). The data is unchanged and in order. Cycles without `up_valid` insert bubbles that never produce a downstream transfer.
- R7: Bubbles are not collapsed. While the last stage is valid and `dn_ready` is 0, `up_ready` is 0 even if every earlier stage is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Reset, active at `RST_LEVEL`, clears the valid flags only |
| clk_en | input | 1 | Active-high global clock enable |
| up_valid | input | 1 | Producer offers an item |
| up_data | input | WIDTH | Producer item |
| up_ready | output | 1 | Pipeline accepts the offered item this cycle |
| dn_valid | output | 1 | Last stage holds an item |
| dn_data | output | WIDTH | Item held in the last stage |
| dn_ready | input | 1 | Consumer takes the item this cycle |
| stage_en | output | 1 | Common clock-enable for all data stages |

## Verification
Streaming is tried four ways: full-rate input with a consumer that is always ready, sparse input with gaps, full-rate input against a consumer that randomly holds back, and sparse input against random backpressure. Full-rate traffic exposes lost or duplicated items, gaps show that bubbles never become outputs, and backpressure shows that a held output stays stable and that the entry stalls. Directed sequences count the exact latency of a single item. One sequence parks an item at the exit so the entry must refuse while the middle stages are empty. Another drops the clock enable while an offered item is waiting and shows that it is neither taken nor advanced.

// File: rtl/lockstep_pipe_pkg.sv
package lockstep_pipe_pkg;

  // Pipeline may move when the exit stage is empty or is being drained.
  function automatic logic may_advance(input logic last_vld, input logic cons_rdy);
    return (!last_vld) || cons_rdy;
  endfunction

  // Reset is active when the pin matches the configured level.
  function automatic logic reset_hit(input logic rst_pin, input logic level);
    return rst_pin == level;
  endfunction

endpackage

// File: rtl/lockstep_valid_track.sv
module lockstep_valid_track #(
  parameter int   DEPTH     = 3,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic clk_en,
  input  logic up_valid,
  input  logic dn_ready,
  output logic stage_en,
  output logic dn_valid
);
  import lockstep_pipe_pkg::*;

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] vld_q;
  logic [DEPTH-1:0] vld_d;
  logic             rst_act;
  logic             move_ok;

  assign rst_act = reset_hit(rst, RST_LEVEL);
  assign move_ok = may_advance(vld_q[LAST], dn_ready);
  assign stage_en = move_ok & clk_en;
  assign dn_valid = vld_q[LAST];

  assign vld_d[0] = up_valid;
  for (genvar s = 1; s < DEPTH; s++) begin : g_link
    assign vld_d[s] = vld_q[s-1];
  end

  always_ff @(posedge clk) begin
    if (rst_act) begin
      vld_q <= '0;
    end else if (stage_en) begin
      vld_q <= vld_d;
    end
  end

endmodule

// File: rtl/lockstep_data_chain.sv
module lockstep_data_chain #(
  parameter int DEPTH = 3,
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             load,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  localparam int LAST = DEPTH - 1;

  logic [WIDTH-1:0] stg_q [DEPTH];

  for (genvar s = 0; s < DEPTH; s++) begin : g_stage
    if (s == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (load) stg_q[0] <= d_in;
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (load) stg_q[s] <= stg_q[s-1];
      end
    end
  end

  assign d_out = stg_q[LAST];

endmodule

// File: rtl/lockstep_pipe.sv
module lockstep_pipe #(
  parameter int   DEPTH     = 3,
  parameter int   WIDTH     = 32,
  parameter logic RST_LEVEL = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_en,
  input  logic             up_valid,
  input  logic [WIDTH-1:0] up_data,
  output logic             up_ready,
  output logic             dn_valid,
  output logic [WIDTH-1:0] dn_data,
  input  logic             dn_ready,
  output logic             stage_en
);

  logic en_w;
  logic up_fire;
  logic dn_fire;

  lockstep_valid_track #(
    .DEPTH     (DEPTH),
    .RST_LEVEL (RST_LEVEL)
  ) u_track (
    .clk      (clk),
    .rst      (rst),
    .clk_en   (clk_en),
    .up_valid (up_valid),
    .dn_ready (dn_ready),
    .stage_en (en_w),
    .dn_valid (dn_valid)
  );

  lockstep_data_chain #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH)
  ) u_chain (
    .clk   (clk),
    .load  (en_w),
    .d_in  (up_data),
    .d_out (dn_data)
  );

  assign stage_en = en_w;
  assign up_ready = en_w;

  // Named transfer events, exposed for observation.
  assign up_fire = up_valid & up_ready;
  assign dn_fire = dn_valid & dn_ready;

endmodule

// File: rtl/lockstep_pipe_chk.sv
module lockstep_pipe_chk #(
  parameter int   WIDTH     = 32,
  parameter logic RST_LEVEL = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             clk_en,
  input logic             up_ready,
  input logic             dn_valid,
  input logic [WIDTH-1:0] dn_data,
  input logic             dn_ready,
  input logic             stage_en
);
  import lockstep_pipe_pkg::*;

  logic rst_act;
  assign rst_act = reset_hit(rst, RST_LEVEL);

  a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst_act)
    $past(rst_act) |-> !dn_valid);

  a_r2_enable_rule: assert property (@(posedge clk) disable iff (rst_act)
    stage_en == (clk_en && (!dn_valid || dn_ready)));

  a_r2_ready_is_enable: assert property (@(posedge clk) disable iff (rst_act)
    up_ready == stage_en);

  a_r3_ce_freezes: assert property (@(posedge clk) disable iff (rst_act)
    (!clk_en && dn_valid) |=> (dn_valid && $stable(dn_data)));

  a_r5_hold_stalled: assert property (@(posedge clk) disable iff (rst_act)
    (dn_valid && !dn_ready) |=> (dn_valid && $stable(dn_data)));

  a_r7_no_collapse: assert property (@(posedge clk) disable iff (rst_act)
    (dn_valid && !dn_ready) |-> !up_ready);

endmodule

bind lockstep_pipe lockstep_pipe_chk #(
  .WIDTH     (WIDTH),
  .RST_LEVEL (RST_LEVEL)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .clk_en   (clk_en),
  .up_ready (up_ready),
  .dn_valid (dn_valid),
  .dn_data  (dn_data),
  .dn_ready (dn_ready),
  .stage_en (stage_en)
);

// File: tb/lockstep_pipe_bench.sv
module lockstep_pipe_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 3;
  localparam int WIDTH = 32;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             clk_en = 1'b1;
  logic             up_valid = 1'b0;
  logic [WIDTH-1:0] up_data = '0;
  logic             up_ready;
  logic             dn_valid;
  logic [WIDTH-1:0] dn_data;
  logic             dn_ready = 1'b0;
  logic             stage_en;

  int checks = 0;
  int failures = 0;
  bit finished = 0;
  bit bp_stop = 0;
  logic [WIDTH-1:0] sb_q [$];
  logic [15:0] lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  lockstep_pipe #(.DEPTH(DEPTH), .WIDTH(WIDTH), .RST_LEVEL(1'b1)) u_lockstep_pipe (
    .clk(clk), .rst(rst), .clk_en(clk_en), .up_valid(up_valid), .up_data(up_data),
    .up_ready(up_ready), .dn_valid(dn_valid), .dn_data(dn_data),
    .dn_ready(dn_ready), .stage_en(stage_en)
  );

  task automatic chk(input bit ok, input string req, input logic [WIDTH-1:0] act,
                     input logic [WIDTH-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic rnd_step();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
  endtask

  // Driver: offer one item, push it to the scoreboard when accepted.
  task automatic send(input logic [WIDTH-1:0] item, input int gap);
    bit taken = 0;
    up_valid = 1'b1;
    up_data  = item;
    while (!taken) begin
      #(CLK_PERIOD/4);
      taken = up_ready;
      if (taken) sb_q.push_back(item);
      @(negedge clk);
    end
    up_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Monitor: compare every downstream transfer with the scoreboard (R6).
  always begin
    @(negedge clk);
    #(CLK_PERIOD/4);
    if (rst == 1'b0 && dn_valid && dn_ready) begin
      if (sb_q.size() == 0) begin
        chk(1'b0, "R6 unexpected output item", dn_data, '0);
      end else begin
        logic [WIDTH-1:0] exp_item;
        exp_item = sb_q.pop_front();
        chk(dn_data == exp_item, "R6 output item order/data", dn_data, exp_item);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog expired", '0, '0);
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    #(CLK_PERIOD/4);
    chk(dn_valid == 1'b0, "R1 dn_valid low in reset", dn_valid, 0);
    @(negedge clk);
    rst = 1'b0;
    #(CLK_PERIOD/4);
    chk(dn_valid == 1'b0, "R1 dn_valid low after reset", dn_valid, 0);
    chk(up_ready == 1'b1, "R1 up_ready high when empty", up_ready, 1);
    chk(stage_en == 1'b1, "R2 stage_en high when empty", stage_en, 1);
    @(negedge clk);

    // R4 latency of a single item
    dn_ready = 1'b1;
    up_valid = 1'b1;
    up_data  = 32'hA000_0001;
    #(CLK_PERIOD/4);
    chk(up_ready == 1'b1, "R4 item accepted", up_ready, 1);
    sb_q.push_back(up_data);
    @(negedge clk);
    up_valid = 1'b0;
    for (int k = 1; k < DEPTH; k++) begin
      #(CLK_PERIOD/4);
      chk(dn_valid == 1'b0, "R4 item not out early", dn_valid, 0);
      @(negedge clk);
    end
    #(CLK_PERIOD/4);
    chk(dn_valid == 1'b1, "R4 item out after DEPTH edges", dn_valid, 1);
    chk(dn_data == 32'hA000_0001, "R4 item data", dn_data, 32'hA000_0001);
    @(negedge clk);
    repeat (2) @(negedge clk);

    // R5/R7 stalled exit with empty earlier stages
    dn_ready = 1'b0;
    send(32'hB000_0002, 0);
    repeat (DEPTH - 1) @(negedge clk);
    up_valid = 1'b1;
    up_data  = 32'hC000_0003;
    for (int k = 0; k < 4; k++) begin
      #(CLK_PERIOD/4);
      chk(up_ready == 1'b0, "R7 entry refuses behind stalled exit", up_ready, 0);
      chk(dn_valid == 1'b1 && dn_data == 32'hB000_0002, "R5 held output stable",
          dn_data, 32'hB000_0002);
      @(negedge clk);
    end
    dn_ready = 1'b1;
    #(CLK_PERIOD/4);
    chk(up_ready == 1'b1, "R2 ready returns when exit drains", up_ready, 1);
    if (up_ready) sb_q.push_back(up_data);
    @(negedge clk);
    up_valid = 1'b0;
    repeat (DEPTH + 2) @(negedge clk);

    // R3 clock enable low freezes everything
    dn_ready = 1'b0;
    send(32'hD000_0004, 0);
    clk_en   = 1'b0;
    up_valid = 1'b1;
    up_data  = 32'hE000_0005;
    for (int k = 0; k < 4; k++) begin
      #(CLK_PERIOD/4);
      chk(up_ready == 1'b0, "R3 up_ready low with clk_en low", up_ready, 0);
      chk(stage_en == 1'b0, "R3 stage_en low with clk_en low", stage_en, 0);
      chk(dn_valid == 1'b0, "R3 no advance with clk_en low", dn_valid, 0);
      @(negedge clk);
    end
    clk_en   = 1'b1;
    up_valid = 1'b0;
    for (int k = 2; k < DEPTH; k++) begin
      #(CLK_PERIOD/4);
      chk(dn_valid == 1'b0, "R3 frozen item resumes in place", dn_valid, 0);
      @(negedge clk);
    end
    @(negedge clk);
    #(CLK_PERIOD/4);
    chk(dn_valid == 1'b1 && dn_data == 32'hD000_0004, "R3 frozen item arrives",
        dn_data, 32'hD000_0004);
    @(negedge clk);
    dn_ready = 1'b1;
    repeat (DEPTH + 2) @(negedge clk);
    chk(sb_q.size() == 0, "R6 directed items all delivered", sb_q.size(), 0);

    // R6 streaming patterns: bit0 = gaps, bit1 = random backpressure
    for (int p = 0; p < 4; p++) begin
      bp_stop = 0;
      fork
        begin
          for (int i = 0; i < 40; i++) begin
            int gap;
            rnd_step();
            gap = (p % 2 == 1) ? int'(lfsr[1:0] % 3) : 0;
            send(WIDTH'(32'h1000_0000 * (p + 1) + i), gap);
          end
          bp_stop = 1;
        end
        begin
          while (!bp_stop) begin
            rnd_step();
            dn_ready = (p >= 2) ? lfsr[3] : 1'b1;
            @(negedge clk);
          end
        end
      join
      dn_ready = 1'b1;
      repeat (DEPTH + 3) @(negedge clk);
      chk(sb_q.size() == 0, "R6 all items delivered per pattern", sb_q.size(), 0);
    end

    finish_run();
  end

endmodule